// File: doc/BRIEF.md
# Segment Lookaside Buffer Array

A small, fully associative table of segment descriptors that turns a 64-bit effective address into a virtual segment ID and a set of protection flags. Each slot holds the two raw operand words it was loaded with and a live valid bit. Every decoded field is taken from those words: the segment ID, the virtual segment ID and the flags. Each slot picks its own segment size for comparison. A slot flagged as a 1 TB segment compares address bits 63:40. Any other slot compares bits 63:28, a 256 MB segment.

Software-style commands arrive on one command port, one per cycle. The commands load a slot from two operand words, load a slot from a legacy 4-bit segment-register number, invalidate the slot an address hits, and invalidate every slot except slot 0. A separate read port returns the stored operand words of any slot. The lookup port and the read port are both registered. Each shows its result one clock after the request. The result reflects the table contents from before any command taken on that same edge.

Top module: `slb_array`

## Requirements
- R1: Command codes on `cmd_i` are 0 idle, 1 indexed load, 2 invalidate by address, 3 invalidate all, 4 segment-register load; other codes do nothing. A lookup on `lk_ea_i` is reported on the outputs after the next rising edge, from the contents before that edge. A miss drives hit, index, VSID and all flags to zero.
- R2: A slot whose valid bit is clear never produces a hit.
- R3: A slot with RS bit 62 set matches when address bits 63:40 equal RB bits 63:40 of its stored ESID word. Any other slot matches on bits 63:28.
- R4: When several valid slots match, the lowest-indexed one is reported on `lk_idx_o` and supplies the fields.
- R5: An indexed load takes the slot index from RB bits 11:0 and the valid bit from RB bit 27, and stores RS and RB. A hit reports VSID = RS bits 63:12, large = RS bit 8, 1 TB = RS bit 62, Ks = RS bit 11, Kp = RS bit 10 and no-execute = RS bit 9. A load whose index is not below the entry count changes nothing.
- R6: The read port returns the stored RB with bits 26:0 cleared, and the stored RS unchanged, one cycle after `rd_idx_i`. An index at or above the entry count reads zero in both words.
- R7: Invalidate by address (address on `cmd_rb_i`) clears only the valid bit of the slot that a lookup of that address would report. On a miss it changes nothing.
- R8: Invalidate all clears the valid bit of every slot from 1 upward, keeps slot 0 as it was, and leaves the stored words untouched.
- R9: A segment-register load with number n = `cmd_rb_i[3:0]` and value v = `cmd_rs_i[31:0]` acts as an indexed load. It uses RB = n<<28 | 1<<27 | n and RS = v[27:0]<<12 | v[30:28]<<9.
- R10: After synchronous reset every slot is invalid with zero words, and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 3 | Command code |
| cmd_rs_i | input | 64 | RS operand word (segment-register value in bits 31:0) |
| cmd_rb_i | input | 64 | RB operand word, or address to invalidate |
| lk_ea_i | input | 64 | Effective address to look up |
| lk_hit_o | output | 1 | Lookup hit |
| lk_idx_o | output | IDX_BITS | Index of the reporting slot |
| lk_vsid_o | output | 52 | Virtual segment ID |
| lk_large_o | output | 1 | Large-page flag |
| lk_tb_o | output | 1 | 1 TB segment flag |
| lk_ks_o | output | 1 | Supervisor key |
| lk_kp_o | output | 1 | Problem-state key |
| lk_nx_o | output | 1 | No-execute flag |
| rd_idx_i | input | 12 | Slot to read back |
| rd_ew_o | output | 64 | Stored ESID word |
| rd_vw_o | output | 64 | Stored VSID word |

## Verification
The bench builds the table with 8 slots. At that size every slot, plus indices just past the end and at the top of the 12-bit range, can be read back and looked up after each phase. The small size puts in reach a rejected load at index 8 and a segment-register number (12) that falls outside the table. It also allows a duplicate segment ID, so priority can be observed first through the lower slot and then, after that slot is invalidated, through the higher one.

// File: rtl/slb_pkg.sv
package slb_pkg;
  localparam int WORD_W      = 64;
  localparam int NUM_W       = 12;
  localparam int VSID_W      = 52;
  localparam int VSID_LO     = 12;
  localparam int RB_VLD_BIT  = 27;
  localparam int SEG_LO_256M = 28;
  localparam int SEG_LO_1T   = 40;
  localparam int RS_TB_BIT   = 62;
  localparam int RS_KS_BIT   = 11;
  localparam int RS_KP_BIT   = 10;
  localparam int RS_NX_BIT   = 9;
  localparam int RS_LG_BIT   = 8;

  typedef enum logic [2:0] {
    SLB_NOP     = 3'd0,
    SLB_LOAD    = 3'd1,
    SLB_INV_EA  = 3'd2,
    SLB_INV_ALL = 3'd3,
    SLB_SEGREG  = 3'd4
  } slb_cmd_e;

  // RB operand synthesized from a legacy segment-register number
  function automatic logic [WORD_W-1:0] segreg_rb(input logic [3:0] n);
    return (64'(n) << SEG_LO_256M) | (64'd1 << RB_VLD_BIT) | 64'(n);
  endfunction

  // RS operand synthesized from a legacy segment-register value
  function automatic logic [WORD_W-1:0] segreg_rs(input logic [31:0] v);
    return (64'(v[27:0]) << VSID_LO) | (64'(v[30:28]) << RS_NX_BIT);
  endfunction
endpackage

// File: rtl/slb_match.sv
module slb_match #(
  parameter int N        = 64,
  parameter int IDX_BITS = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]                        valid_i,
  input  logic [N-1:0][slb_pkg::WORD_W-1:28]  seg_i,
  input  logic [N-1:0]                        tb_i,
  input  logic [slb_pkg::WORD_W-1:0]          ea_i,
  output logic                                hit_o,
  output logic [IDX_BITS-1:0]                 idx_o
);
  import slb_pkg::*;

  logic [N-1:0] match;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_cmp
      always_comb begin
        if (tb_i[g])
          match[g] = valid_i[g] && (ea_i[WORD_W-1:SEG_LO_1T] == seg_i[g][WORD_W-1:SEG_LO_1T]);
        else
          match[g] = valid_i[g] && (ea_i[WORD_W-1:SEG_LO_256M] == seg_i[g][WORD_W-1:SEG_LO_256M]);
      end
    end
  endgenerate

  // lowest index wins: scan downward so the last assignment is the lowest
  always_comb begin
    hit_o = |match;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--)
      if (match[i]) idx_o = IDX_BITS'(i);
  end
endmodule

// File: rtl/slb_store.sv
module slb_store #(
  parameter int N        = 64,
  parameter int IDX_BITS = (N > 1) ? $clog2(N) : 1
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [2:0]                         cmd_i,
  input  logic [slb_pkg::WORD_W-1:0]         rs_i,
  input  logic [slb_pkg::WORD_W-1:0]         rb_i,
  input  logic                               inv_hit_i,
  input  logic [IDX_BITS-1:0]                inv_idx_i,
  output logic [N-1:0]                       valid_o,
  output logic [N-1:0][slb_pkg::WORD_W-1:0]  ew_o,
  output logic [N-1:0][slb_pkg::WORD_W-1:0]  vw_o
);
  import slb_pkg::*;

  logic [N-1:0]             valid_q;
  logic [N-1:0][WORD_W-1:0] ew_q;
  logic [N-1:0][WORD_W-1:0] vw_q;

  logic              is_load;
  logic [WORD_W-1:0] wr_rb;
  logic [WORD_W-1:0] wr_rs;
  logic [NUM_W-1:0]  wr_num;
  logic              wr_ok;
  logic [IDX_BITS-1:0] wr_sel;

  always_comb begin
    is_load = (cmd_i == SLB_LOAD) || (cmd_i == SLB_SEGREG);
    wr_rb   = (cmd_i == SLB_SEGREG) ? segreg_rb(rb_i[3:0])  : rb_i;
    wr_rs   = (cmd_i == SLB_SEGREG) ? segreg_rs(rs_i[31:0]) : rs_i;
    wr_num  = wr_rb[NUM_W-1:0];
    wr_ok   = is_load && (32'(wr_num) < N);
    wr_sel  = wr_num[IDX_BITS-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      ew_q    <= '0;
      vw_q    <= '0;
    end else begin
      if (wr_ok) begin
        ew_q[wr_sel]    <= {wr_rb[WORD_W-1:RB_VLD_BIT], {RB_VLD_BIT{1'b0}}};
        vw_q[wr_sel]    <= wr_rs;
        valid_q[wr_sel] <= wr_rb[RB_VLD_BIT];
      end
      if (cmd_i == SLB_INV_EA && inv_hit_i)
        valid_q[inv_idx_i] <= 1'b0;
      if (cmd_i == SLB_INV_ALL)
        valid_q[N-1:1] <= '0;
    end
  end

  assign valid_o = valid_q;
  assign ew_o    = ew_q;
  assign vw_o    = vw_q;

  assert_load_oob_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (is_load && !(32'(wr_num) < N)) |=> ($stable(valid_q) && $stable(ew_q) && $stable(vw_q)));

  assert_load_sets_valid_R5: assert property (@(posedge clk) disable iff (rst)
    wr_ok |=> (valid_q[$past(wr_sel)] == $past(wr_rb[RB_VLD_BIT])));

  assert_inv_miss_stable_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd_i == SLB_INV_EA && !inv_hit_i) |=> $stable(valid_q));

  assert_inv_all_spares0_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_i == SLB_INV_ALL) |=> (valid_q[N-1:1] == '0 && valid_q[0] == $past(valid_q[0])
                                && $stable(ew_q) && $stable(vw_q)));
endmodule

// File: rtl/slb_array.sv
module slb_array #(
  parameter int N        = 64,
  parameter int IDX_BITS = (N > 1) ? $clog2(N) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [2:0]           cmd_i,
  input  logic [63:0]          cmd_rs_i,
  input  logic [63:0]          cmd_rb_i,
  input  logic [63:0]          lk_ea_i,
  output logic                 lk_hit_o,
  output logic [IDX_BITS-1:0]  lk_idx_o,
  output logic [51:0]          lk_vsid_o,
  output logic                 lk_large_o,
  output logic                 lk_tb_o,
  output logic                 lk_ks_o,
  output logic                 lk_kp_o,
  output logic                 lk_nx_o,
  input  logic [11:0]          rd_idx_i,
  output logic [63:0]          rd_ew_o,
  output logic [63:0]          rd_vw_o
);
  import slb_pkg::*;

  logic [N-1:0]             valid;
  logic [N-1:0][WORD_W-1:0] ew;
  logic [N-1:0][WORD_W-1:0] vw;
  logic [N-1:0][WORD_W-1:28] seg;
  logic [N-1:0]             tb;

  logic                lk_hit, inv_hit;
  logic [IDX_BITS-1:0] lk_idx, inv_idx;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_dec
      assign seg[g] = ew[g][WORD_W-1:28];
      assign tb[g]  = vw[g][RS_TB_BIT];
    end
  endgenerate

  slb_store #(.N(N), .IDX_BITS(IDX_BITS)) u_store (
    .clk(clk), .rst(rst), .cmd_i(cmd_i), .rs_i(cmd_rs_i), .rb_i(cmd_rb_i),
    .inv_hit_i(inv_hit), .inv_idx_i(inv_idx),
    .valid_o(valid), .ew_o(ew), .vw_o(vw)
  );

  slb_match #(.N(N), .IDX_BITS(IDX_BITS)) u_lookup (
    .valid_i(valid), .seg_i(seg), .tb_i(tb), .ea_i(lk_ea_i),
    .hit_o(lk_hit), .idx_o(lk_idx)
  );

  slb_match #(.N(N), .IDX_BITS(IDX_BITS)) u_invsel (
    .valid_i(valid), .seg_i(seg), .tb_i(tb), .ea_i(cmd_rb_i),
    .hit_o(inv_hit), .idx_o(inv_idx)
  );

  logic [WORD_W-1:0] hit_vw;
  assign hit_vw = vw[lk_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_hit_o   <= 1'b0;
      lk_idx_o   <= '0;
      lk_vsid_o  <= '0;
      lk_large_o <= 1'b0;
      lk_tb_o    <= 1'b0;
      lk_ks_o    <= 1'b0;
      lk_kp_o    <= 1'b0;
      lk_nx_o    <= 1'b0;
      rd_ew_o    <= '0;
      rd_vw_o    <= '0;
    end else begin
      lk_hit_o   <= lk_hit;
      lk_idx_o   <= lk_hit ? lk_idx : '0;
      lk_vsid_o  <= lk_hit ? hit_vw[WORD_W-1:VSID_LO] : '0;
      lk_large_o <= lk_hit & hit_vw[RS_LG_BIT];
      lk_tb_o    <= lk_hit & hit_vw[RS_TB_BIT];
      lk_ks_o    <= lk_hit & hit_vw[RS_KS_BIT];
      lk_kp_o    <= lk_hit & hit_vw[RS_KP_BIT];
      lk_nx_o    <= lk_hit & hit_vw[RS_NX_BIT];
      if (32'(rd_idx_i) < N) begin
        rd_ew_o <= ew[rd_idx_i[IDX_BITS-1:0]];
        rd_vw_o <= vw[rd_idx_i[IDX_BITS-1:0]];
      end else begin
        rd_ew_o <= '0;
        rd_vw_o <= '0;
      end
    end
  end

  assert_read_oob_zero_R6: assert property (@(posedge clk) disable iff (rst)
    !(32'(rd_idx_i) < N) |=> (rd_ew_o == '0 && rd_vw_o == '0));

  assert_hit_from_valid_R2: assert property (@(posedge clk) disable iff (rst)
    lk_hit |=> (lk_hit_o && $past(valid[lk_idx])));

  assert_miss_zero_R1: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |=> (lk_idx_o == '0 && lk_vsid_o == '0 && !lk_tb_o && !lk_nx_o));
endmodule

// File: tb/test_slb_array.sv
module test_slb_array;
  localparam int N  = 8;
  localparam int IB = 3;

  logic clk = 1'b0;
  logic rst;
  logic [2:0]  cmd;
  logic [63:0] rs, rb, ea;
  logic [11:0] ridx;
  logic        hit, lg, tbf, ks, kp, nx;
  logic [IB-1:0] idx;
  logic [51:0] vsid;
  logic [63:0] rew, rvw;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  slb_array #(.N(N)) i_slb_array (
    .clk(clk), .rst(rst), .cmd_i(cmd), .cmd_rs_i(rs), .cmd_rb_i(rb),
    .lk_ea_i(ea), .lk_hit_o(hit), .lk_idx_o(idx), .lk_vsid_o(vsid),
    .lk_large_o(lg), .lk_tb_o(tbf), .lk_ks_o(ks), .lk_kp_o(kp), .lk_nx_o(nx),
    .rd_idx_i(ridx), .rd_ew_o(rew), .rd_vw_o(rvw)
  );

  // bench model of the table, kept from the requirements
  logic [63:0] m_e [N];
  logic [63:0] m_v [N];
  logic        m_ok[N];

  function automatic void mlook(input logic [63:0] a, output logic h, output int k);
    h = 1'b0; k = 0;
    for (int i = 0; i < N; i++) begin
      logic m;
      m = m_v[i][62] ? (a[63:40] == m_e[i][63:40]) : (a[63:28] == m_e[i][63:28]);
      if (m_ok[i] && m && !h) begin h = 1'b1; k = i; end
    end
  endfunction

  function automatic void mload(input logic [63:0] s, input logic [63:0] b);
    int k;
    k = int'(b[11:0]);
    if (k < N) begin
      m_e[k]  = {b[63:27], 27'b0};
      m_v[k]  = s;
      m_ok[k] = b[27];
    end
  endfunction

  task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // one command cycle with lookup and read-back checked afterwards
  task automatic step(input string tag, input logic [2:0] c, input logic [63:0] s,
                      input logic [63:0] b, input logic [63:0] a, input logic [11:0] r);
    logic h; int k;
    logic [127:0] exp_lk, exp_rd;
    cmd = c; rs = s; rb = b; ea = a; ridx = r;
    mlook(a, h, k);
    if (h) exp_lk = {59'b0, 1'b1, 3'(k), m_v[k][63:12], m_v[k][8], m_v[k][62],
                     m_v[k][11], m_v[k][10], m_v[k][9]};
    else   exp_lk = '0;
    exp_rd = (int'(r) < N) ? {m_e[int'(r)], m_v[int'(r)]} : '0;
    @(posedge clk);
    #1;
    case (c)
      3'd1: mload(s, b);
      3'd2: begin
        logic hh; int kk;
        mlook(b, hh, kk);
        if (hh) m_ok[kk] = 1'b0;
      end
      3'd3: for (int i = 1; i < N; i++) m_ok[i] = 1'b0;
      3'd4: mload((64'(s[27:0]) << 12) | (64'(s[30:28]) << 9),
                  (64'(b[3:0]) << 28) | (64'd1 << 27) | 64'(b[3:0]));
      default: ;
    endcase
    @(negedge clk);
    chk({tag, " lookup"}, {59'b0, hit, idx, vsid, lg, tbf, ks, kp, nx}, exp_lk);
    chk({tag, " readback"}, {rew, rvw}, exp_rd);
  endtask

  function automatic logic [35:0] seg_of(input int k);
    if (k == 7) return seg_of(2);
    if (k == 5) return {24'hABC, 12'h005};
    return 36'h1000 + 36'(k) * 36'h11;
  endfunction

  function automatic logic [63:0] rb_of(input int k);
    return {seg_of(k), (k != 6), 15'(k * 32'h1111), 12'(k)};
  endfunction

  function automatic logic [63:0] rs_of(input int k);
    logic [63:0] v;
    v = {52'h1_0000_0000 + 52'(k) * 52'h3_1415, 12'b0};
    v[62] = (k == 5);
    v[11:7] = 5'(k * 7);
    return v;
  endfunction

  function automatic logic [63:0] ea_of(input int k);
    if (k < N) return {seg_of(k), 28'(k * 32'h1234)};
    if (k == 8) return {24'hABC, 12'h777, 28'h0};
    if (k == 9) return 64'h3 << 28;
    return 64'hDEAD << 28;
  endfunction

  task automatic sweep(input string tag);
    for (int k = 0; k < 11; k++) step(tag, 3'd0, '0, '0, ea_of(k), 12'(k));
    step({tag, " top index"}, 3'd0, '0, '0, ea_of(8), 12'hFFF);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_e[i] = '0; m_v[i] = '0; m_ok[i] = 1'b0; end
    cmd = '0; rs = '0; rb = '0; ea = '0; ridx = '0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 reset outputs", {59'b0, hit, idx, vsid, lg, tbf, ks, kp, nx, rew[0]}, '0);
    rst = 1'b0;
    sweep("R10 after reset");

    // loads; lookup of the slot being loaded sees old contents (R1)
    for (int k = 0; k < N; k++)
      step("R1 R5 load same-cycle", 3'd1, rs_of(k), rb_of(k), ea_of(k), 12'(k));
    sweep("R2 R3 R4 R5 R6 loaded");

    // loads at or above the entry count are dropped (R5)
    step("R5 oob 8", 3'd1, rs_of(1), {36'h777, 1'b1, 15'h0, 12'd8}, '0, 12'd8);
    step("R5 oob fff", 3'd1, rs_of(1), {36'h777, 1'b1, 15'h0, 12'hFFF}, 64'h777 << 28, 12'd8);
    step("R5 oob lookup", 3'd0, '0, '0, 64'h777 << 28, 12'd9);
    sweep("R5 R6 after oob");

    step("R7 inv miss", 3'd2, '0, 64'hDEAD << 28, '0, 12'd0);
    sweep("R7 after miss");
    step("R7 inv hit", 3'd2, '0, ea_of(2), ea_of(2), 12'd2);
    sweep("R4 R7 after hit");

    step("R9 segreg 3", 3'd4, 64'h0000_0000_7ABC_DEF1, 64'h3, ea_of(9), 12'd3);
    step("R9 segreg 12", 3'd4, 64'h0000_0000_5123_4567, 64'hC, 64'hC << 28, 12'd12);
    step("R9 segreg 12 lookup", 3'd0, '0, '0, 64'hC << 28, 12'd3);
    sweep("R9 after segreg");

    step("R8 inv all", 3'd3, '0, '0, ea_of(0), 12'd0);
    sweep("R8 after inv all");

    step("R1 unused code", 3'd7, rs_of(4), rb_of(4), ea_of(4), 12'd4);
    step("R2 load invalid 0", 3'd1, rs_of(0), {seg_of(0), 1'b0, 15'h0, 12'd0}, ea_of(0), 12'd0);
    sweep("R2 after invalid load");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule